// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block turns one host request into the pin-level waveform for a single access to an 8-bit NAND flash device. The bus is shared and carries command, address and data bytes. The host presents a request with a direction, a byte and a byte kind (command, address or data). The request takes effect when the sequencer is idle. The sequencer then walks through four timed phases, all counted in system clock cycles:

- an address/control setup phase;
- a strobe phase, during which read enable or write enable is held low;
- a hold phase;
- in parallel with the others, a write-only bus turnaround window that keeps the data bus released for a while after the access starts.

The device's active-low ready/busy line stretches the strobe phase beyond its programmed minimum for as long as the device reports busy. On reads, the sequencer captures the byte from the bus at the end of the strobe and presents it with a one-cycle done pulse. Command and address bytes are always written, so a host can issue any number of address bytes in a row as separate requests.

The bus is modelled as separate input, output and output-enable vectors, and the pad is expected to merge them. Timing values are taken from the configuration inputs at the moment a request is accepted, and they stay fixed for that access.

Top module: `nand_access_seq`

## Requirements
- R1: A request (`req_valid` high) is accepted only in a cycle where `busy` is low. `busy` is high from the next cycle until the done cycle. Requests presented while `busy` is high are ignored and start no access.
- R2: The setup phase lasts `cfg_setup`+1 cycles, starting with the first busy cycle. Both strobes stay high during it. The latch lines and the output byte stay constant throughout the access.
- R3: The strobe phase lasts at least `cfg_wait`+1 cycles. `wr_n` is low for write accesses and `rd_n` is low for read accesses. The two are never low together, and neither is low outside an access.
- R4: While `rdy_n` is sampled low at the end of the minimum strobe time, the strobe stays asserted. It is released after the first clock edge at which `rdy_n` is high.
- R5: The hold phase lasts `cfg_hold` cycles, and a value of 0 acts as 1. `done` pulses for one cycle right after the last hold cycle, and `busy` is already low in that cycle.
- R6: On a read, `dq_in` is captured at the clock edge that ends the strobe phase. It appears on `rd_data` by the done cycle and stays unchanged until the next read's capture.
- R7: On a write, `dq_oe` stays low for the first `cfg_hiz` cycles of the access, counted from the first setup cycle. After that it is high, with `dq_out` equal to the request byte, until the access ends. `dq_oe` is never high on a read or while idle.
- R8: The byte kind is encoded as follows: `req_kind` 2'b01 is a command and raises `cle`; 2'b10 is an address and raises `ale`; 2'b00 and 2'b11 are data, with both lines low. Command and address accesses are always writes, whatever `req_write` says.
- R9: During and right after reset, `rd_n` and `wr_n` are high, `ale`, `cle`, `dq_oe`, `busy` and `done` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read (data kind only) |
| req_kind | input | 2 | Byte kind: 00 data, 01 command, 10 address, 11 data |
| req_byte | input | DW | Byte to drive on a write |
| cfg_setup | input | CW | Setup length minus one |
| cfg_wait | input | CW | Minimum strobe length minus one |
| cfg_hold | input | CW | Hold length (0 acts as 1) |
| cfg_hiz | input | CW | Write bus release cycles from access start |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DW | Byte captured on the last read |
| rd_n | output | 1 | Active-low read enable |
| wr_n | output | 1 | Active-low write enable |
| ale | output | 1 | Address latch enable |
| cle | output | 1 | Command latch enable |
| dq_out | output | DW | Bus output byte |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | DW | Bus input byte |
| rdy_n | input | 1 | Active-low device busy (low = busy) |

## Verification
The bench builds the block with its default parameters: an 8-bit bus and 8-bit phase counters. With these, every timing field spans its full legal range, but the bench drives only small counts so that each access stays within tens of cycles.

The small counts are still enough to reach the interesting cases:
- the one-cycle minimum for every phase;
- a hold value of 0;
- a bus-release value that is longer than the whole access, so the bus is never driven;
- a device-busy stretch that outlasts the minimum strobe.

The bench measures phase lengths and the first driven cycle directly at the pins, for each vector.

// File: rtl/nfc_seq_pkg.sv
// Package: shared phase and byte-kind encodings for the NAND access sequencer.
// Assumes a 2-bit kind field; kind 2'b11 is treated as data.
package nfc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    localparam logic [1:0] KIND_DATA = 2'b00;
    localparam logic [1:0] KIND_CMD  = 2'b01;
    localparam logic [1:0] KIND_ADDR = 2'b10;
endpackage

// File: rtl/nfc_phase_ctrl.sv
// Module: phase controller. Accepts a request when idle, latches the timing
// fields, and steps through setup, strobe and hold with one shared counter.
// The strobe is held at its minimum count while the device reports busy.
// Assumes cfg values are meaningful only at the acceptance edge.
module nfc_phase_ctrl
    import nfc_seq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_hold,
    input  logic          rdy_n,
    output phase_e        phase,
    output logic          accept,
    output logic          strobe_exit,
    output logic          done
);
    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] setup_q;
    logic [CW-1:0] wait_q;
    logic [CW-1:0] hold_last_q;
    logic          done_q;

    // Decode acceptance and strobe completion from the current phase.
    always_comb begin
        accept      = req_valid && (phase_q == PH_IDLE);
        strobe_exit = (phase_q == PH_STROBE) && (cnt_q == wait_q) && rdy_n;
    end

    // Phase sequencing, per-phase counting and done pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            setup_q     <= '0;
            wait_q      <= '0;
            hold_last_q <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q     <= PH_SETUP;
                        cnt_q       <= '0;
                        setup_q     <= cfg_setup;
                        wait_q      <= cfg_wait;
                        hold_last_q <= (cfg_hold == '0) ? '0 : cfg_hold - 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == setup_q) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt_q == wait_q) begin
                        if (rdy_n) begin
                            phase_q <= PH_HOLD;
                            cnt_q   <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == hold_last_q) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;
    assign done  = done_q;

    AST_ACCEPT_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (phase_q == PH_SETUP)); // R1
    AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE) |-> (cnt_q <= wait_q)); // R3
    AST_BUSY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE && cnt_q == wait_q && !rdy_n) |=> (phase_q == PH_STROBE)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R5
endmodule

// File: rtl/nfc_bus_drive.sv
// Module: pin driver. Latches the request byte, kind and direction at
// acceptance, derives the latch lines and strobes from the phase, and
// releases the data bus on writes until the turnaround count has elapsed.
// Assumes the phase input comes from nfc_phase_ctrl.
module nfc_bus_drive
    import nfc_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  phase_e        phase,
    input  logic          req_write,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_byte,
    input  logic [CW-1:0] cfg_hiz,
    output logic          is_write,
    output logic          rd_n,
    output logic          wr_n,
    output logic          ale,
    output logic          cle,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    logic          wr_q;
    logic [1:0]    kind_q;
    logic [DW-1:0] byte_q;
    logic [CW-1:0] hiz_q;
    logic [CW-1:0] elapsed_q;
    logic          active;

    // Request fields captured at acceptance; command and address force a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            kind_q <= KIND_DATA;
            byte_q <= '0;
            hiz_q  <= '0;
        end else if (accept) begin
            wr_q   <= req_write || (req_kind == KIND_CMD) || (req_kind == KIND_ADDR);
            kind_q <= req_kind;
            byte_q <= req_byte;
            hiz_q  <= cfg_hiz;
        end
    end

    // Saturating count of cycles elapsed since the access started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (accept) begin
            elapsed_q <= '0;
        end else if (active && (elapsed_q != '1)) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    // Pin levels decoded from the phase and the latched request.
    always_comb begin
        active   = (phase != PH_IDLE);
        is_write = wr_q;
        rd_n     = !((phase == PH_STROBE) && !wr_q);
        wr_n     = !((phase == PH_STROBE) && wr_q);
        ale      = active && (kind_q == KIND_ADDR);
        cle      = active && (kind_q == KIND_CMD);
        dq_out   = byte_q;
        dq_oe    = active && wr_q && (elapsed_q >= hiz_q);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R3
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && cle)); // R8
    AST_NO_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (wr_q && active)); // R7
    AST_LINES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable({ale, cle, dq_out})); // R2
endmodule

// File: rtl/nfc_read_capture.sv
// Module: read capture register. Samples the bus on the edge that ends a
// read strobe and holds the byte until the next read capture.
// Assumes strobe_exit marks the final strobe cycle.
module nfc_read_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_exit,
    input  logic          is_write,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] rd_data
);
    logic          cap_en;
    logic [DW-1:0] data_q;

    // Capture only at the end of a read strobe.
    always_comb cap_en = strobe_exit && !is_write;

    // Hold the most recently read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cap_en) begin
            data_q <= dq_in;
        end
    end

    assign rd_data = data_q;

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(data_q)); // R6
endmodule

// File: rtl/nand_access_seq.sv
// Module: top of the NAND access sequencer. Wires the phase controller,
// pin driver and read capture together. Assumes the pad merges dq_out,
// dq_oe and dq_in into one bidirectional bus.
module nand_access_seq
    import nfc_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_byte,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_hiz,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          rd_n,
    output logic          wr_n,
    output logic          ale,
    output logic          cle,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    input  logic [DW-1:0] dq_in,
    input  logic          rdy_n
);
    phase_e phase;
    logic   accept;
    logic   strobe_exit;
    logic   is_write;

    nfc_phase_ctrl #(.CW(CW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .cfg_setup   (cfg_setup),
        .cfg_wait    (cfg_wait),
        .cfg_hold    (cfg_hold),
        .rdy_n       (rdy_n),
        .phase       (phase),
        .accept      (accept),
        .strobe_exit (strobe_exit),
        .done        (done)
    );

    nfc_bus_drive #(.DW(DW), .CW(CW)) drive_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .phase     (phase),
        .req_write (req_write),
        .req_kind  (req_kind),
        .req_byte  (req_byte),
        .cfg_hiz   (cfg_hiz),
        .is_write  (is_write),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ale       (ale),
        .cle       (cle),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    nfc_read_capture #(.DW(DW)) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_exit (strobe_exit),
        .is_write    (is_write),
        .dq_in       (dq_in),
        .rd_data     (rd_data)
    );

    // Busy covers every non-idle phase.
    always_comb busy = (phase != PH_IDLE);

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
endmodule

// File: tb/nand_access_seq_tb_top.sv
module nand_access_seq_tb_top;
    localparam int DW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [DW-1:0] req_byte = '0;
    logic [CW-1:0] cfg_setup = '0;
    logic [CW-1:0] cfg_wait = '0;
    logic [CW-1:0] cfg_hold = '0;
    logic [CW-1:0] cfg_hiz = '0;
    logic          busy, done, rd_n, wr_n, ale, cle, dq_oe;
    logic [DW-1:0] rd_data, dq_out;
    logic [DW-1:0] dq_in = '0;
    logic          rdy_n = 1'b1;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    nand_access_seq #(.DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_kind(req_kind), .req_byte(req_byte), .cfg_setup(cfg_setup),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_hiz(cfg_hiz),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_n(rd_n), .wr_n(wr_n),
        .ale(ale), .cle(cle), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
        .rdy_n(rdy_n)
    );

    typedef struct packed {
        logic [7:0] s;
        logic [7:0] w;
        logic [7:0] h;
        logic [7:0] hiz;
        logic       wr;
        logic [1:0] kind;
        logic [7:0] byt;
        logic [7:0] din;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{8'd0, 8'd0, 8'd1, 8'd0,  1'b1, 2'b01, 8'h70, 8'h00},
        '{8'd2, 8'd3, 8'd2, 8'd1,  1'b1, 2'b10, 8'h12, 8'h00},
        '{8'd1, 8'd2, 8'd3, 8'd0,  1'b0, 2'b00, 8'h00, 8'hA5},
        '{8'd4, 8'd1, 8'd1, 8'd5,  1'b1, 2'b00, 8'h3C, 8'h00},
        '{8'd0, 8'd0, 8'd1, 8'd20, 1'b1, 2'b11, 8'h55, 8'h00},
        '{8'd3, 8'd0, 8'd0, 8'd2,  1'b0, 2'b01, 8'h9D, 8'h00}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // One access; release_k > 0 holds rdy_n low until after sample release_k.
    task automatic run_acc(input int s, input int w, input int h, input int hiz,
                           input bit wr, input logic [1:0] kind,
                           input logic [7:0] byt, input logic [7:0] din,
                           input int release_k, input bit poke);
        int S = s + 1;
        int W = w + 1;
        int H = (h == 0) ? 1 : h;
        bit is_wr = wr || (kind == 2'b01) || (kind == 2'b10);
        int We;
        int oe_exp;
        int k = 0;
        int setup_c = 0, strobe_c = 0, hold_c = 0, oe_first = 0, done_k = 0;
        bit seen_strobe = 0, bad_dq = 0, bad_lines = 0, bad_dir = 0, both = 0;
        bit done_busy = 0;
        bit exp_ale = (kind == 2'b10);
        bit exp_cle = (kind == 2'b01);
        We = W;
        if (release_k > 0 && (release_k - S) > W) We = release_k - S;
        oe_exp = (is_wr && (hiz < S + We + H)) ? hiz + 1 : 0;
        @(negedge clk);
        cfg_setup = s[7:0]; cfg_wait = w[7:0]; cfg_hold = h[7:0]; cfg_hiz = hiz[7:0];
        req_write = wr; req_kind = kind; req_byte = byt; req_valid = 1'b1;
        dq_in = (release_k > 0) ? 8'hFF : din;
        rdy_n = (release_k > 0) ? 1'b0 : 1'b1;
        while (done_k == 0 && k < 3000) begin
            @(negedge clk);
            k++;
            if (done) begin
                done_k = k;
                done_busy = busy;
            end else if (busy) begin
                if (!rd_n || !wr_n) begin
                    strobe_c++;
                    seen_strobe = 1;
                    if (is_wr ? (wr_n || !rd_n) : (rd_n || !wr_n)) bad_dir = 1;
                end else if (!seen_strobe) setup_c++;
                else hold_c++;
                if (ale !== exp_ale || cle !== exp_cle) bad_lines = 1;
            end
            if (!rd_n && !wr_n) both = 1;
            if (dq_oe && oe_first == 0) oe_first = k;
            if (dq_oe && dq_out !== byt) bad_dq = 1;
            if (k == 1) req_valid = 1'b0;
            if (poke && k == 2) begin
                req_valid = 1'b1; req_write = 1'b0; req_kind = 2'b00; req_byte = ~byt;
            end
            if (poke && k == 3) req_valid = 1'b0;
            if (release_k == k) begin rdy_n = 1'b1; dq_in = din; end
        end
        chk(setup_c == S, "R2 setup length", setup_c, S);
        chk(strobe_c == We, (release_k > 0) ? "R4 stretched strobe length" : "R3 strobe length", strobe_c, We);
        chk(!bad_dir && !both, "R3 strobe polarity/exclusion", {bad_dir, both}, 0);
        chk(hold_c == H, "R5 hold length", hold_c, H);
        chk(done_k == S + We + H + 1 && !done_busy, "R5 done timing, busy low", done_k, S + We + H + 1);
        chk(oe_first == oe_exp, "R7 first driven cycle", oe_first, oe_exp);
        chk(!bad_dq, "R7 driven byte", bad_dq, 0);
        chk(!bad_lines, "R8 latch lines", bad_lines, 0);
        if (!is_wr) chk(rd_data == din, "R6 captured byte", rd_data, din);
        if (poke) begin
            @(negedge clk);
            chk(!busy, "R1 request during busy ignored", busy, 0);
            @(negedge clk);
            chk(!busy && dq_oe == 1'b0, "R1 no second access", busy, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(rd_n && wr_n && !ale && !cle && !dq_oe && !busy && !done && rd_data == 0,
            "R9 reset outputs", {rd_n, wr_n, ale, cle, dq_oe, busy, done}, 7'b1100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && rd_n && wr_n, "R9 idle after reset", busy, 0);

        for (int i = 0; i < 6; i++) begin
            run_acc(VECS[i].s, VECS[i].w, VECS[i].h, VECS[i].hiz, VECS[i].wr,
                    VECS[i].kind, VECS[i].byt, VECS[i].din, 0, 1'b0);
        end

        // R4: device busy outlasts the minimum strobe; read captures late byte.
        run_acc(1, 1, 1, 0, 1'b0, 2'b00, 8'h00, 8'h5E, 9, 1'b0);
        // R6: a following write leaves the read byte untouched.
        run_acc(0, 0, 1, 0, 1'b1, 2'b00, 8'hC3, 8'h00, 0, 1'b0);
        chk(rd_data == 8'h5E, "R6 read byte held across write", rd_data, 8'h5E);
        // R1: a request presented during an access is ignored.
        run_acc(1, 1, 2, 0, 1'b1, 2'b10, 8'h44, 8'h00, 0, 1'b1);
        // R4: busy that ends before the minimum does not stretch.
        run_acc(0, 4, 1, 0, 1'b1, 2'b01, 8'hFF, 8'h00, 2, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule